// File: doc/BRIEF.md
# Gated Decimal Frequency Counter with Static LCD Drive

This block measures the frequency of an external pulse stream. A slow crystal reference, nominally 32768 Hz, is divided down to a fixed gate window; during that window every rising edge of the measured input advances a chain of binary-coded-decimal decades. At the close of each window the result is captured into a display register and then presented on a static segment LCD. A single backplane alternates at a low rate, so every panel electrode sees a waveform with no DC component.

The decades are clocked by the measured signal itself, so the input can run much faster than any system clock. Two control levels cross into the input domain through two-flop synchronizers, and a completion flag crosses back. The chain is cleared only after its value has been captured. The displayed number is the edge count in one window, so the window length in reference cycles sets the unit. The default of 16384 cycles is half a second, and the display then reads half the frequency in Hz.

If the input has no edges, the completion flag never returns. In that case a bounded wait in the reference domain ends the measurement and the display shows zero.

Top module: `freq_counter_lcd`

## Requirements
- R1: The gate stays open for exactly GATE_CYCLES reference cycles per measurement. The reading equals the number of rising input edges that fall inside that window.
- R2: The reading is shown in decimal over DIGITS digit positions. Digit position k (k = 0 is the least significant) drives lcdSeg[7k+6:7k].
- R3: A count above the largest DIGITS-digit value wraps modulo 10^DIGITS. The over-range electrode lcdOver is then driven on for the whole time that reading is displayed, and it is off for any reading that did not wrap.
- R4: Each digit is shown as seven segments, bit 0 = a through bit 6 = g. The patterns for 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex); a blanked digit is 00.
- R5: Zeros above the most significant non-zero digit are blanked. Position 0 is always shown, so a reading of zero displays a single 0.
- R6: lcdBp toggles every BP_HALF reference cycles. Every segment output and lcdOver equals its on-state XOR lcdBp, so each output is the exact complement of itself across a backplane change.
- R7: readingStrobe is a one-cycle pulse in the cycle a new reading appears. Between pulses the displayed pattern, taken as the outputs XOR lcdBp, does not change.
- R8: If no completion arrives within TIMEOUT_CYCLES reference cycles after the gate closes, a reading of zero with no over-range is displayed and a new gate opens.
- R9: Each measurement starts from a count of zero. The clear request to the input domain is raised only in the cycle the captured reading appears, and the gate is never open while the clear request is raised.
- R10: While rstN is low, the display shows a single 0, lcdBp is low, lcdOver is off and readingStrobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Crystal reference clock that sets the gate timing and the LCD timing |
| rstN | input | 1 | Active-low asynchronous reset for both clock domains |
| sigIn | input | 1 | Measured pulse stream; also the clock of the decade chain |
| lcdSeg | output | DIGITS*7 | Segment electrodes, 7 per digit, each XORed with the backplane |
| lcdOver | output | 1 | Over-range electrode XORed with the backplane |
| lcdBp | output | 1 | LCD backplane, a square wave |
| readingStrobe | output | 1 | One-cycle pulse marking a new displayed reading |

## Verification
The hardest states to reach are a reading that has wrapped past the top decade and the no-edge timeout path. The bench reaches the first by running a second instance with only two decades, so that ordinary input rates overflow it while the six-digit instance reads them normally. It reaches the second by holding the input idle after reset. Input rates change between windows, and the reading that spans a rate change is deliberately left unscored. Input half-periods are even while reference edges fall on multiples of 40, so input and reference edges never coincide and every scored count is exact.

// File: rtl/fcnt_pkg.sv
`timescale 1ns/1ps
package fcnt_pkg;

  // Strobes and levels from the control to the datapath
  typedef struct packed {
    logic gateOpen;    // level, crosses into the input domain
    logic clearReq;    // level, crosses into the input domain
    logic latchCount;  // one-cycle pulse: capture the frozen chain
    logic latchZero;   // one-cycle pulse: show zero after a timeout
    logic backplane;   // LCD backplane level
  } ctrlStrobe_t;

  // Seven-segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] segOf(input logic [3:0] digit);
    case (digit)
      4'd0: segOf = 7'h3F;
      4'd1: segOf = 7'h06;
      4'd2: segOf = 7'h5B;
      4'd3: segOf = 7'h4F;
      4'd4: segOf = 7'h66;
      4'd5: segOf = 7'h6D;
      4'd6: segOf = 7'h7D;
      4'd7: segOf = 7'h07;
      4'd8: segOf = 7'h7F;
      4'd9: segOf = 7'h6F;
      default: segOf = 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/fcnt_ctrl.sv
`timescale 1ns/1ps
module fcnt_ctrl
  import fcnt_pkg::*;
#(
  parameter int GATE_CYCLES    = 16384,
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int BP_HALF        = 256
) (
  input  logic        refClk,
  input  logic        rstN,
  input  logic        doneSeen,
  output ctrlStrobe_t strobes
);

  localparam int LIMIT  = (GATE_CYCLES > TIMEOUT_CYCLES) ? GATE_CYCLES : TIMEOUT_CYCLES;
  localparam int TICK_W = $clog2(LIMIT + 1);
  localparam int BP_W   = $clog2(BP_HALF + 1);

  typedef enum logic [1:0] {S_OPEN, S_DRAIN, S_LATCH, S_CLEAR} phase_t;

  phase_t            phase;
  logic [TICK_W-1:0] tick;
  logic              gateQ, clearQ, latchQ, zeroQ;
  logic [BP_W-1:0]   bpCnt;
  logic              bpQ;

  // Measurement sequence: open gate, wait for the frozen count, capture, clear
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      phase  <= S_OPEN;
      tick   <= '0;
      gateQ  <= 1'b1;
      clearQ <= 1'b0;
      latchQ <= 1'b0;
      zeroQ  <= 1'b0;
    end else begin
      latchQ <= 1'b0;
      zeroQ  <= 1'b0;
      case (phase)
        S_OPEN: begin
          if (tick == TICK_W'(GATE_CYCLES - 1)) begin
            gateQ <= 1'b0;
            tick  <= '0;
            phase <= S_DRAIN;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        S_DRAIN: begin
          if (doneSeen) begin
            latchQ <= 1'b1;
            phase  <= S_LATCH;
          end else if (tick == TICK_W'(TIMEOUT_CYCLES - 1)) begin
            zeroQ <= 1'b1;
            gateQ <= 1'b1;
            tick  <= '0;
            phase <= S_OPEN;
          end else begin
            tick <= tick + 1'b1;
          end
        end
        S_LATCH: begin
          clearQ <= 1'b1;   // raised only after the capture edge
          phase  <= S_CLEAR;
        end
        S_CLEAR: begin
          if (!doneSeen) begin
            clearQ <= 1'b0;
            gateQ  <= 1'b1;
            tick   <= '0;
            phase  <= S_OPEN;
          end
        end
        default: phase <= S_OPEN;
      endcase
    end
  end

  // Backplane square wave
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      bpCnt <= '0;
      bpQ   <= 1'b0;
    end else if (bpCnt == BP_W'(BP_HALF - 1)) begin
      bpCnt <= '0;
      bpQ   <= ~bpQ;
    end else begin
      bpCnt <= bpCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.gateOpen   = gateQ;
    strobes.clearReq   = clearQ;
    strobes.latchCount = latchQ;
    strobes.latchZero  = zeroQ;
    strobes.backplane  = bpQ;
  end

endmodule

// File: rtl/fcnt_datapath.sv
`timescale 1ns/1ps
module fcnt_datapath
  import fcnt_pkg::*;
#(
  parameter int DIGITS = 6
) (
  input  logic                  refClk,
  input  logic                  sigIn,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobes,
  output logic                  doneSeen,
  output logic [DIGITS*4-1:0]   countBcd,
  output logic [DIGITS*7-1:0]   lcdSeg,
  output logic                  lcdOver,
  output logic                  lcdBp,
  output logic                  readingStrobe
);

  localparam int BCD_W = DIGITS * 4;
  localparam int SEG_W = DIGITS * 7;

  // ---------------- input-clock domain ----------------
  logic [1:0] gateSync, clearSync;
  logic       gatePrev, doneFlag, overFlag;
  logic       gateS, clrS, cntEn;
  logic [3:0] digitQ [DIGITS];
  logic [DIGITS-1:0] isNine;
  logic [DIGITS:0]   carry;
  logic [DIGITS:0]   nineMask;

  always_ff @(posedge sigIn or negedge rstN) begin
    if (!rstN) begin
      gateSync  <= '0;
      clearSync <= '0;
      gatePrev  <= 1'b0;
    end else begin
      gateSync  <= {gateSync[0], strobes.gateOpen};
      clearSync <= {clearSync[0], strobes.clearReq};
      gatePrev  <= gateSync[1];
    end
  end

  assign gateS    = gateSync[1];
  assign clrS     = clearSync[1];
  assign cntEn    = gateS & ~clrS;
  assign nineMask = {isNine, 1'b1};

  for (genvar k = 0; k < DIGITS; k++) begin : g_decade
    assign isNine[k] = (digitQ[k] == 4'd9);
    assign carry[k]  = cntEn & (&nineMask[k:0]);
    assign countBcd[k*4 +: 4] = digitQ[k];
    always_ff @(posedge sigIn or negedge rstN) begin
      if (!rstN)          digitQ[k] <= 4'd0;
      else if (clrS)      digitQ[k] <= 4'd0;
      else if (carry[k])  digitQ[k] <= isNine[k] ? 4'd0 : digitQ[k] + 4'd1;
    end
  end
  assign carry[DIGITS] = cntEn & (&nineMask);

  // Done is set on the synchronized gate's falling edge, dropped by the clear
  always_ff @(posedge sigIn or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      overFlag <= 1'b0;
    end else if (clrS) begin
      doneFlag <= 1'b0;
      overFlag <= 1'b0;
    end else begin
      if (gatePrev && !gateS) doneFlag <= 1'b1;
      if (carry[DIGITS])      overFlag <= 1'b1;
    end
  end

  // ---------------- reference domain ----------------
  logic [1:0]       doneSync;
  logic [BCD_W-1:0] shownBcd;
  logic             shownOver;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) doneSync <= '0;
    else       doneSync <= {doneSync[0], doneFlag};
  end
  assign doneSeen = doneSync[1];

  // The chain is frozen while done is seen, so the capture is stable
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      shownBcd      <= '0;
      shownOver     <= 1'b0;
      readingStrobe <= 1'b0;
    end else begin
      readingStrobe <= strobes.latchCount | strobes.latchZero;
      if (strobes.latchCount) begin
        shownBcd  <= countBcd;
        shownOver <= overFlag;
      end else if (strobes.latchZero) begin
        shownBcd  <= '0;
        shownOver <= 1'b0;
      end
    end
  end

  // Leading-zero blanking and segment drive
  logic [DIGITS-1:0] blankMask;
  logic [SEG_W-1:0]  segOn;

  always_comb begin
    logic zeroAbove;
    zeroAbove = 1'b1;
    blankMask = '0;
    for (int k = DIGITS - 1; k >= 1; k--) begin
      zeroAbove    = zeroAbove & (shownBcd[k*4 +: 4] == 4'd0);
      blankMask[k] = zeroAbove;
    end
  end

  for (genvar k = 0; k < DIGITS; k++) begin : g_seg
    assign segOn[k*7 +: 7] = blankMask[k] ? 7'h00 : segOf(shownBcd[k*4 +: 4]);
  end

  assign lcdBp   = strobes.backplane;
  assign lcdSeg  = segOn ^ {SEG_W{strobes.backplane}};
  assign lcdOver = shownOver ^ strobes.backplane;

endmodule

// File: rtl/freq_counter_lcd.sv
`timescale 1ns/1ps
module freq_counter_lcd
  import fcnt_pkg::*;
#(
  parameter int DIGITS         = 6,
  parameter int GATE_CYCLES    = 16384,
  parameter int TIMEOUT_CYCLES = 1024,
  parameter int BP_HALF        = 256
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                sigIn,
  output logic [DIGITS*7-1:0] lcdSeg,
  output logic                lcdOver,
  output logic                lcdBp,
  output logic                readingStrobe
);

  ctrlStrobe_t         strobes;
  logic                doneSeen;
  logic [DIGITS*4-1:0] countBcd;
  logic                gateOpenW, clearReqW;

  fcnt_ctrl #(
    .GATE_CYCLES(GATE_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .BP_HALF(BP_HALF)
  ) u_ctrl (
    .refClk(refClk),
    .rstN(rstN),
    .doneSeen(doneSeen),
    .strobes(strobes)
  );

  fcnt_datapath #(
    .DIGITS(DIGITS)
  ) u_dp (
    .refClk(refClk),
    .sigIn(sigIn),
    .rstN(rstN),
    .strobes(strobes),
    .doneSeen(doneSeen),
    .countBcd(countBcd),
    .lcdSeg(lcdSeg),
    .lcdOver(lcdOver),
    .lcdBp(lcdBp),
    .readingStrobe(readingStrobe)
  );

  assign gateOpenW = strobes.gateOpen;
  assign clearReqW = strobes.clearReq;

endmodule

// File: rtl/fcnt_checker.sv
`timescale 1ns/1ps
module fcnt_checker #(
  parameter int DIGITS      = 6,
  parameter int GATE_CYCLES = 16384
) (
  input logic                refClk,
  input logic                sigIn,
  input logic                rstN,
  input logic                gateOpen,
  input logic                clearReq,
  input logic                readingStrobe,
  input logic [DIGITS*7-1:0] lcdSeg,
  input logic                lcdOver,
  input logic                lcdBp,
  input logic [DIGITS*4-1:0] countBcd
);

  localparam int RUN_W = $clog2(GATE_CYCLES + 1) + 1;

  logic [RUN_W-1:0] gateRun;
  logic             bcdOk;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)         gateRun <= '0;
    else if (gateOpen) gateRun <= gateRun + 1'b1;
    else               gateRun <= '0;
  end

  always_comb begin
    bcdOk = 1'b1;
    for (int k = 0; k < DIGITS; k++)
      if (countBcd[k*4 +: 4] > 4'd9) bcdOk = 1'b0;
  end

  assert_gate_max_R1: assert property (@(posedge refClk) disable iff (!rstN)
    gateOpen |-> (gateRun < RUN_W'(GATE_CYCLES)));

  assert_gate_exact_R1: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(gateOpen) |-> ($past(gateRun) == RUN_W'(GATE_CYCLES - 1)));

  assert_decades_bcd_R2: assert property (@(posedge sigIn) disable iff (!rstN)
    bcdOk);

  assert_over_held_R3: assert property (@(posedge refClk) disable iff (!rstN)
    !readingStrobe |-> ((lcdOver ^ lcdBp) == $past(lcdOver ^ lcdBp)));

  assert_bp_invert_R6: assert property (@(posedge refClk) disable iff (!rstN)
    (!readingStrobe && (lcdBp != $past(lcdBp))) |->
      ((lcdSeg == ~$past(lcdSeg)) && (lcdOver != $past(lcdOver))));

  assert_display_steady_R7: assert property (@(posedge refClk) disable iff (!rstN)
    (!readingStrobe && $stable(lcdBp)) |-> ($stable(lcdSeg) && $stable(lcdOver)));

  assert_clear_after_capture_R9: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(clearReq) |-> readingStrobe);

  assert_no_gate_in_clear_R9: assert property (@(posedge refClk) disable iff (!rstN)
    clearReq |-> !gateOpen);

endmodule

bind freq_counter_lcd fcnt_checker #(
  .DIGITS(DIGITS),
  .GATE_CYCLES(GATE_CYCLES)
) u_fcnt_checker (
  .refClk(refClk),
  .sigIn(sigIn),
  .rstN(rstN),
  .gateOpen(gateOpenW),
  .clearReq(clearReqW),
  .readingStrobe(readingStrobe),
  .lcdSeg(lcdSeg),
  .lcdOver(lcdOver),
  .lcdBp(lcdBp),
  .countBcd(countBcd)
);

// File: tb/freq_counter_lcd_bench.sv
`timescale 1ns/1ps
module freq_counter_lcd_bench;

  localparam int REF_PERIOD = 80;
  localparam int GATE       = 16;
  localparam int TMO        = 8;
  localparam int BPH        = 4;

  typedef struct { int value; bit over; } expItem_t;

  logic        refClk = 1'b0;
  logic        rstN   = 1'b0;
  logic        sigIn  = 1'b0;
  int          sigHalf = 0;

  logic [41:0] segMain;
  logic        overMain, bpMain, strobeMain;
  logic [13:0] segSmall;
  logic        overSmall, bpSmall, strobeSmall;

  int total = 0;
  int bad   = 0;
  expItem_t mainQ[$];
  expItem_t smallQ[$];
  logic [41:0] lastPat;

  always #(REF_PERIOD/2) refClk = ~refClk;

  // Input stream: even half-periods from an odd start never meet a reference edge
  initial begin
    wait (sigHalf != 0);
    #1;
    forever #(sigHalf) sigIn = ~sigIn;
  end

  freq_counter_lcd #(.DIGITS(6), .GATE_CYCLES(GATE), .TIMEOUT_CYCLES(TMO), .BP_HALF(BPH))
    u_freq_counter_lcd (.refClk(refClk), .rstN(rstN), .sigIn(sigIn), .lcdSeg(segMain),
      .lcdOver(overMain), .lcdBp(bpMain), .readingStrobe(strobeMain));

  freq_counter_lcd #(.DIGITS(2), .GATE_CYCLES(GATE), .TIMEOUT_CYCLES(TMO), .BP_HALF(BPH))
    u_freq_counter_lcd_small (.refClk(refClk), .rstN(rstN), .sigIn(sigIn), .lcdSeg(segSmall),
      .lcdOver(overSmall), .lcdBp(bpSmall), .readingStrobe(strobeSmall));

  function automatic logic [6:0] expSeg(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  // Expected on-pattern with leading-zero blanking (R4, R5)
  function automatic logic [41:0] expPattern(int value, int digits);
    logic [41:0] p = '0;
    int v = value;
    int hi = 0;
    int d [6];
    for (int k = 0; k < 6; k++) begin
      d[k] = v % 10;
      v = v / 10;
      if (d[k] != 0 && k < digits) hi = k;
    end
    for (int k = 0; k < digits; k++)
      if (k <= hi) p[k*7 +: 7] = expSeg(d[k]);
    return p;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic waitReading;
    @(negedge refClk);
    while (!strobeMain) @(negedge refClk);
    @(posedge refClk);
  endtask

  // Driver: change rate, skip the straddling reading, score the next one
  task automatic measure(int half, int edges);
    expItem_t m, s;
    sigHalf = half;
    waitReading;
    m.value = edges;        m.over = 1'b0;
    s.value = edges % 100;  s.over = (edges > 99);
    mainQ.push_back(m);
    smallQ.push_back(s);
    waitReading;
  endtask

  // Monitor for the six-digit instance
  initial lastPat = expPattern(0, 6);
  always @(negedge refClk) begin
    if (rstN) begin
      logic [41:0] dec;
      dec = segMain ^ {42{bpMain}};
      if (strobeMain) begin
        if (mainQ.size() > 0) begin
          expItem_t e;
          e = mainQ.pop_front();
          // R1 R2 R4 R5 R9: exact count from zero, decimal, encoded, blanked; R8 for the zero entry
          check(dec == expPattern(e.value, 6), "R1 R2 R4 R5 R8 R9", "main segments", dec, expPattern(e.value, 6));
          check((overMain ^ bpMain) == e.over, "R3", "main over-range", overMain ^ bpMain, e.over);
        end
        lastPat = dec;
      end else begin
        check(dec == lastPat, "R7", "display steady between readings", dec, lastPat);
      end
    end
  end

  // Monitor for the two-digit instance
  always @(negedge refClk) begin
    if (rstN && strobeSmall && smallQ.size() > 0) begin
      expItem_t e;
      logic [13:0] dec;
      e = smallQ.pop_front();
      dec = segSmall ^ {14{bpSmall}};
      check(dec == expPattern(e.value, 2), "R3", "small wrapped digits", dec, expPattern(e.value, 2));
      check((overSmall ^ bpSmall) == e.over, "R3", "small over-range", overSmall ^ bpSmall, e.over);
    end
  end

  // Backplane half-period (R6)
  initial begin
    int run = 0;
    int seen = 0;
    logic prevBp = 1'b0;
    wait (rstN);
    forever begin
      @(negedge refClk);
      run++;
      if (bpMain != prevBp) begin
        if (seen > 0 && seen < 8)
          check(run == BPH, "R6", "backplane half period", run, BPH);
        seen++;
        run = 0;
        prevBp = bpMain;
      end
    end
  end

  initial begin
    #(REF_PERIOD * 20000);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired: actual=hung expected=done");
    finishRun;
  end

  initial begin
    expItem_t z;
    logic [41:0] p0, p1;
    logic o0, o1;
    repeat (3) @(posedge refClk);
    @(negedge refClk);
    check(segMain == expPattern(0, 6), "R10", "reset segments", segMain, expPattern(0, 6));
    check(bpMain == 1'b0, "R10", "reset backplane", bpMain, 0);
    check(overMain == 1'b0, "R10", "reset over-range", overMain, 0);
    check(strobeMain == 1'b0, "R10", "reset strobe", strobeMain, 0);
    // R8: input idle, first reading comes from the timeout
    z.value = 0; z.over = 1'b0;
    mainQ.push_back(z);
    smallQ.push_back(z);
    rstN = 1'b1;
    waitReading;
    measure(4, 160);    // small wraps to 60 with over-range
    measure(10, 64);
    measure(40, 16);
    measure(2, 320);    // small wraps to 20 with over-range
    check(mainQ.size() == 0, "R7", "all readings strobed", mainQ.size(), 0);
    // R6: outputs invert across a backplane change
    @(negedge refClk);
    while (bpMain != 1'b0 || strobeMain) @(negedge refClk);
    p0 = segMain; o0 = overMain;
    while (bpMain != 1'b1) @(negedge refClk);
    p1 = segMain; o1 = overMain;
    check(p1 == ~p0, "R6", "segments inverted", p1, ~p0);
    check(o1 == ~o0, "R6", "over-range inverted", o1, ~o0);
    repeat (4) @(posedge refClk);
    finishRun;
  end

endmodule